// File: doc/BRIEF.md
# Countdown Interval Timer

This block is a 32-bit countdown timer on a small pipelined bus slave port. Software programs it with a single write. The top bit chooses between one-shot and auto-restart operation, and the remaining bits give the start value, which is also the reload value. While the count-enable input is high, the count drops by one each clock. In a system this input is driven by a "processor running" signal, so the timer stops whenever a debugger holds the processor.

When the count leaves 1, the timer emits a single-clock timeout pulse. In one-shot mode the count then rests at zero. In auto-restart mode it reloads the programmed value and keeps counting without any help from software. Writing a start value of zero leaves the timer idle.

A build-time parameter chooses where the pulse goes. An interval timer sends it to the interrupt output. A watchdog sends it to the reset-request output, and the counting is the same in both builds.

The bus port acknowledges every strobe exactly one clock later and never stalls. Because the port never stalls, no back-pressure rule applies. Reads return the mode bit and the live count.

Top module: `cdn_timer`

## Requirements
- R1: A synchronous reset sets the count to 0 and the mode to one-shot, and drives ack, interrupt and reset-request low.
- R2: A write (cyc, stb and we high together) loads the count from data bits 30:0 and the mode from bit 31 (1 = auto-restart, 0 = one-shot). The new count is visible to a read strobed on the following clock.
- R3: On each clock with count-enable high and a non-zero count, the count drops by exactly one. With count-enable low, the count holds its value.
- R4: In one-shot mode, an enabled clock at count 1 moves the count to 0. The count then stays at 0 until the next write.
- R5: In auto-restart mode, an enabled clock at count 1 loads the last written start value, so the timeout repeats every start-value enabled clocks.
- R6: The timeout is high for exactly the one clock after each edge at which an enabled count left 1. At all other times it is low, including whenever the count rests at 0.
- R7: Writing a start value of 0 leaves the timer idle at 0 and produces no timeout, whatever the mode bit says.
- R8: Ack is high exactly on the clock after each clock with cyc and stb high, and at no other time. Stall is always low. The read data shown with ack is {mode, count} as they stood on the strobe clock.
- R9: A write on the same clock as an enabled count leaving 1 wins over the automatic reload and the stop: the written value is loaded. The timeout pulse for that crossing is still produced.
- R10: With WATCHDOG=0 the timeout appears on the interrupt output and the reset-request output stays low. With WATCHDOG=1 these roles are swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cnt_en_i | input | 1 | Count enable (processor running) |
| bus_cyc_i | input | 1 | Bus cycle active |
| bus_stb_i | input | 1 | Bus strobe |
| bus_we_i | input | 1 | Write enable |
| bus_wdata_i | input | DATA_W | Write data: mode bit in the top bit, start value below it |
| bus_ack_o | output | 1 | Acknowledge, one clock after each strobe |
| bus_stall_o | output | 1 | Stall, always low |
| bus_rdata_o | output | DATA_W | Read data {mode, count}, valid with ack |
| irq_o | output | 1 | Timeout pulse when WATCHDOG=0 |
| rst_req_o | output | 1 | Timeout pulse when WATCHDOG=1 |

## Verification
The countdown is tried four ways, each with a read strobed on every clock:
- One-shot runs separate resting at zero from reloading.
- Auto-restart runs with short and long start values separate the reload value from a stale value, and catch a pulse that comes one clock early or late.
- Irregular count-enable patterns, including enable low exactly at count 1, show whether the freeze and the pulse qualification are correct.
- Writes that land on the crossing clock, zero start values and the largest 31-bit value cover the priority and the width edges.

Two builds, an interval timer and a watchdog, share the same stimulus. This tells apart which output receives the pulse.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic {
    MODE_ONESHOT = 1'b0,
    MODE_AUTO    = 1'b1
  } tmr_mode_e;

  function automatic tmr_mode_e tmr_mode_of(input logic b);
    return b ? MODE_AUTO : MODE_ONESHOT;
  endfunction
endpackage

// File: rtl/tmr_bus_slave.sv
module tmr_bus_slave #(
  parameter int DATA_W = 32,
  localparam int CNT_W = DATA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              cyc_i,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] cur_word_i,
  output logic              ack_o,
  output logic              stall_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              wr_o,
  output tmr_pkg::tmr_mode_e wr_mode_o,
  output logic [CNT_W-1:0]  wr_value_o
);
  logic strobe;

  assign strobe     = cyc_i && stb_i;
  assign wr_o       = strobe && we_i;
  assign wr_mode_o  = tmr_pkg::tmr_mode_of(wdata_i[DATA_W-1]);
  assign wr_value_o = wdata_i[CNT_W-1:0];
  assign stall_o    = 1'b0;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ack_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      ack_o <= strobe;
      if (strobe) rdata_o <= cur_word_i;
    end
  end

  AST_ACK_AFTER_STB: assert property (@(posedge clk_i) disable iff (rst_i)
    (cyc_i && stb_i) |=> ack_o); // R8
  AST_NO_SPURIOUS_ACK: assert property (@(posedge clk_i) disable iff (rst_i)
    !(cyc_i && stb_i) |=> !ack_o); // R8
  AST_RDATA_SNAPSHOT: assert property (@(posedge clk_i) disable iff (rst_i)
    (cyc_i && stb_i) |=> rdata_o == $past(cur_word_i)); // R8
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 31
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               en_i,
  input  logic               wr_i,
  input  tmr_pkg::tmr_mode_e wr_mode_i,
  input  logic [CNT_W-1:0]   wr_value_i,
  output logic [CNT_W-1:0]   count_o,
  output tmr_pkg::tmr_mode_e mode_o,
  output logic               expire_o
);
  import tmr_pkg::*;

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] reload_q;
  logic             at_one;
  logic             crossing;

  assign at_one   = (count_o == ONE);
  assign crossing = en_i && at_one;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      count_o  <= '0;
      reload_q <= '0;
      mode_o   <= MODE_ONESHOT;
      expire_o <= 1'b0;
    end else begin
      expire_o <= crossing;
      if (wr_i) begin
        count_o  <= wr_value_i;
        reload_q <= wr_value_i;
        mode_o   <= wr_mode_i;
      end else if (en_i && (count_o != '0)) begin
        if (at_one)
          count_o <= (mode_o == MODE_AUTO) ? reload_q : '0;
        else
          count_o <= count_o - ONE;
      end
    end
  end

  AST_WRITE_LOADS: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_i |=> count_o == $past(wr_value_i)); // R2
  AST_STEP_DOWN: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && !wr_i && count_o > ONE) |=> count_o == $past(count_o) - ONE); // R3
  AST_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
    (!en_i && !wr_i) |=> $stable(count_o)); // R3
  AST_ONESHOT_STOP: assert property (@(posedge clk_i) disable iff (rst_i)
    (crossing && !wr_i && mode_o == MODE_ONESHOT) |=> count_o == '0); // R4
  AST_REST_AT_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    (count_o == '0 && !wr_i) |=> count_o == '0); // R4
  AST_AUTO_RELOAD: assert property (@(posedge clk_i) disable iff (rst_i)
    (crossing && !wr_i && mode_o == MODE_AUTO) |=> count_o != '0); // R5
  AST_PULSE_ON_CROSS: assert property (@(posedge clk_i) disable iff (rst_i)
    crossing |=> expire_o); // R6
  AST_NO_HOLD_AT_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    (count_o == '0 && expire_o) |=> !expire_o); // R6
  AST_ZERO_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
    (count_o == '0) |=> !expire_o); // R7
endmodule

// File: rtl/tmr_out_route.sv
module tmr_out_route #(
  parameter bit WATCHDOG = 1'b0
) (
  input  logic pulse_i,
  output logic irq_o,
  output logic rst_req_o
);
  generate
    if (WATCHDOG) begin : g_watchdog
      assign irq_o     = 1'b0;
      assign rst_req_o = pulse_i;
    end else begin : g_interval
      assign irq_o     = pulse_i;
      assign rst_req_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/cdn_timer.sv
module cdn_timer #(
  parameter int DATA_W   = 32,
  parameter bit WATCHDOG = 1'b0,
  localparam int CNT_W   = DATA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              cnt_en_i,
  input  logic              bus_cyc_i,
  input  logic              bus_stb_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic              bus_ack_o,
  output logic              bus_stall_o,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  import tmr_pkg::*;

  logic             wr;
  tmr_mode_e        wr_mode;
  logic [CNT_W-1:0] wr_value;
  logic [CNT_W-1:0] count;
  tmr_mode_e        mode;
  logic             expire;
  logic [DATA_W-1:0] cur_word;

  assign cur_word = {mode, count};

  tmr_bus_slave #(.DATA_W(DATA_W)) u_bus (
    .clk_i(clk_i), .rst_i(rst_i),
    .cyc_i(bus_cyc_i), .stb_i(bus_stb_i), .we_i(bus_we_i),
    .wdata_i(bus_wdata_i), .cur_word_i(cur_word),
    .ack_o(bus_ack_o), .stall_o(bus_stall_o), .rdata_o(bus_rdata_o),
    .wr_o(wr), .wr_mode_o(wr_mode), .wr_value_o(wr_value)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(cnt_en_i),
    .wr_i(wr), .wr_mode_i(wr_mode), .wr_value_i(wr_value),
    .count_o(count), .mode_o(mode), .expire_o(expire)
  );

  tmr_out_route #(.WATCHDOG(WATCHDOG)) u_route (
    .pulse_i(expire), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr && cnt_en_i && count == CNT_W'(1)) |=> (expire && count == $past(wr_value))); // R9
  AST_RESET_STATE: assert property (@(posedge clk_i)
    rst_i |=> (!bus_ack_o && !irq_o && !rst_req_o)); // R1
endmodule

// File: tb/cdn_timer_test.sv
module cdn_timer_test;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [DW-1:0] wdata = '0;

  logic ack, stall, irq, rreq;
  logic [DW-1:0] rdata;
  logic ack_w, stall_w, irq_w, rreq_w;
  logic [DW-1:0] rdata_w;

  always #4 clk = ~clk;

  cdn_timer #(.DATA_W(DW), .WATCHDOG(1'b0)) uut (
    .clk_i(clk), .rst_i(rst), .cnt_en_i(en),
    .bus_cyc_i(cyc), .bus_stb_i(stb), .bus_we_i(we), .bus_wdata_i(wdata),
    .bus_ack_o(ack), .bus_stall_o(stall), .bus_rdata_o(rdata),
    .irq_o(irq), .rst_req_o(rreq));

  cdn_timer #(.DATA_W(DW), .WATCHDOG(1'b1)) uut_wd (
    .clk_i(clk), .rst_i(rst), .cnt_en_i(en),
    .bus_cyc_i(cyc), .bus_stb_i(stb), .bus_we_i(we), .bus_wdata_i(wdata),
    .bus_ack_o(ack_w), .bus_stall_o(stall_w), .bus_rdata_o(rdata_w),
    .irq_o(irq_w), .rst_req_o(rreq_w));

  // behavioural reference
  longint unsigned m_cnt = 0, m_rel = 0;
  bit m_auto = 0, m_pulse = 0, m_ack = 0;
  longint unsigned m_rd = 0;

  int compared = 0, mismatched = 0;
  int cycles = 0;
  string phase = "R1";

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      m_cnt <= 0; m_rel <= 0; m_auto <= 0; m_pulse <= 0; m_ack <= 0; m_rd <= 0;
    end else begin
      m_ack   <= cyc && stb;
      if (cyc && stb) m_rd <= {m_auto, 31'(m_cnt)};
      m_pulse <= en && (m_cnt == 1);
      if (cyc && stb && we) begin
        m_cnt  <= wdata[30:0];
        m_rel  <= wdata[30:0];
        m_auto <= wdata[31];
      end else if (en && m_cnt != 0) begin
        if (m_cnt == 1) m_cnt <= m_auto ? m_rel : 0;
        else            m_cnt <= m_cnt - 1;
      end
    end
  end

  task automatic check(input bit ok, input string what, input longint unsigned act,
                       input longint unsigned exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0h expected=%0h at cycle %0d", phase, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check(ack == m_ack, "R8 ack", ack, m_ack);
      check(stall == 1'b0, "R8 stall", stall, 0);
      check(irq == m_pulse, "R6 irq pulse", irq, m_pulse);
      check(rreq == 1'b0, "R10 interval rst_req", rreq, 0);
      check(rreq_w == m_pulse, "R10 watchdog rst_req", rreq_w, m_pulse);
      check(irq_w == 1'b0, "R10 watchdog irq", irq_w, 0);
      if (m_ack) begin
        check(rdata == m_rd, "R2 read word", rdata, m_rd);
        check(rdata_w == m_rd, "R10 watchdog read word", rdata_w, m_rd);
      end
    end
  end

  task automatic step(input bit c, input bit s, input bit w, input logic [DW-1:0] d,
                      input bit e);
    @(negedge clk);
    cyc = c; stb = s; we = w; wdata = d; en = e;
  endtask

  task automatic wr_word(input logic [DW-1:0] d, input bit e);
    step(1, 1, 1, d, e);
  endtask

  task automatic run_reads(input int n, input bit e);
    for (int i = 0; i < n; i++) step(1, 1, 0, '0, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    phase = "R1";
    rst = 1'b0;
    run_reads(3, 1);
    check(rdata == 0, "R1 count after reset", rdata, 0);

    phase = "R4";
    wr_word({1'b0, 31'd5}, 1);
    run_reads(10, 1);
    check(rdata == 0, "R4 one-shot rests at 0", rdata, 0);

    phase = "R3";
    wr_word({1'b0, 31'd6}, 0);
    for (int i = 0; i < 18; i++) step(1, 1, 0, '0, (i % 3) != 0);

    phase = "R6";
    wr_word({1'b1, 31'd2}, 1);
    step(1, 1, 0, '0, 1);
    for (int i = 0; i < 4; i++) step(1, 1, 0, '0, 0); // enable low at count 1
    run_reads(6, 1);

    phase = "R5";
    wr_word({1'b1, 31'd4}, 1);
    run_reads(15, 1);
    wr_word({1'b1, 31'd1}, 1);
    run_reads(4, 1);

    phase = "R7";
    wr_word({1'b1, 31'd0}, 1);
    run_reads(8, 1);
    wr_word({1'b0, 31'd0}, 1);
    run_reads(4, 1);
    check(rdata == 0, "R7 zero start idle", rdata, 0);

    phase = "R9";
    wr_word({1'b1, 31'd3}, 1);
    for (int g = 0; g < 8 && m_cnt != 1; g++) step(1, 1, 0, '0, 1);
    wr_word({1'b1, 31'd7}, 1);
    run_reads(10, 1);
    wr_word({1'b0, 31'd2}, 1);
    step(1, 1, 0, '0, 1);
    wr_word({1'b0, 31'd3}, 1);
    run_reads(6, 1);

    phase = "R8";
    wr_word({1'b0, 31'd20}, 1);
    for (int i = 0; i < 12; i++) step(i % 2, (i % 3) != 0, 0, '0, 1);
    step(0, 1, 1, {1'b1, 31'd9}, 1); // stb without cyc: no ack, no write
    run_reads(2, 0);
    step(1, 0, 1, {1'b1, 31'd9}, 1); // cyc without stb: no ack, no write
    run_reads(2, 0);

    phase = "R2";
    wr_word({1'b0, 31'h7FFF_FFFF}, 1);
    run_reads(5, 1);

    phase = "R1";
    wr_word({1'b1, 31'd3}, 1);
    run_reads(2, 1);
    @(negedge clk); rst = 1'b1; cyc = 0; stb = 0; we = 0;
    @(negedge clk);
    check(ack == 0 && irq == 0 && rreq_w == 0, "R1 outputs during reset", ack, 0);
    rst = 1'b0;
    run_reads(3, 1);
    check(rdata == 0, "R1 count after mid-run reset", rdata, 0);
    step(0, 0, 0, '0, 0);
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    wait (cycles >= 20000);
    compared++;
    mismatched++;
    $display("FAIL watchdog expired (R1..R10 incomplete): actual=%0d expected<%0d", cycles, 20000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule